// File: doc/BRIEF.md
# Processor Clock-Stop Controller

This block sits between the system oscillator and a fully static processor. It lets software put the processor to sleep by stopping its clock, and it starts that clock again on request. It watches the processor bus on every rising edge of the system clock.

Software first writes to a chosen address in supervisor data space. It then runs the halt instruction, whose immediate operand is fetched over the bus. The controller counts acknowledged bus cycles, beginning with that write. Once the operand fetch has finished, it turns the processor clock off at the next falling edge of the system clock.

An external wake request turns the clock back on, also at a falling edge. The number of cycles to count depends on the data-bus width. With a 16-bit bus the operand arrives in one cycle. With an 8-bit bus it takes two.

Top module: `clkstop_ctrl`

## Requirements
- R1: A cycle arms the sequence only if all of the following hold: the address equals `sleepAddr`, `rdWr` is 0 (a write), and `funcCode` is 3'b101. A cycle that is a read, has any other function code, or has another address leaves the clock running.
- R2: A bus cycle counts only when `asN` returns high after `ackN` was sampled low while `asN` was low. A cycle that ends without that acknowledge is not counted, even if it matches.
- R3: With `byteMode`=0, the clock stops after the second counted cycle (the matching write is the first). The last `cpuClk` pulse is the high phase that starts at the rising edge on which the end of that cycle is sampled. No pulse follows it.
- R4: With `byteMode`=1, the clock stops after the third counted cycle. After only two counted cycles the clock keeps running.
- R5: Call the first rising edge that samples `wakeReq` high while stopped edge 0. `cpuClk` stays low at edges 0, 1 and 2, and its first high phase begins at edge 3.
- R6: `cpuClk` is either low or copies a complete high phase of `sysClk`. Its enable changes only while `sysClk` is low, so every high pulse lasts exactly half a system clock period.
- R7: While `resetReq` is high, `cpuClk` runs. Reset discards any partly counted sequence, so after reset one ordinary cycle does not stop the clock.
- R8: `wakeReq` has no effect while the clock runs. After a wake the count starts from zero, so the clock stops again only after a new matching write.
- R9: Any 24-bit value is a valid `sleepAddr`, including the top of the range. A value that differs from it only in bit 0 does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock |
| resetReq | input | 1 | Asynchronous reset request, active high |
| wakeReq | input | 1 | Asynchronous wake request, active high |
| addrBus | input | 24 | Processor address bus |
| rdWr | input | 1 | 1 = read, 0 = write |
| funcCode | input | 3 | Processor function code |
| asN | input | 1 | Address strobe, active low |
| ackN | input | 1 | Transfer acknowledge, active low |
| byteMode | input | 1 | Static bus width select: 1 = 8-bit, 0 = 16-bit |
| sleepAddr | input | 24 | Address whose supervisor write arms the stop |
| cpuClk | output | 1 | Gated processor clock |

## Verification
The end of a bus cycle is seen at the rising edge after `asN` goes high. When that cycle is the last one, its own high phase is the final `cpuClk` pulse, so the bench counts pulses four edges later and expects exactly one more. A wake request crosses two synchronizer stages and the controller register, so the bench checks that no pulse has appeared after three edges and that exactly one has appeared after the fourth. The bench drives every input at falling edges. It reads pulse counts one time unit after rising edges, so each count is taken only after the gate flop, which updates at the falling edge, has settled.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HALT  = 2'd2
  } ctlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadOne;
    logic incCnt;
    logic clrCnt;
    logic wantRun;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic cycleEnd;
    logic cycleMatch;
    logic atFinal;
  } busStat_t;

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= RESET_VAL;
        else      chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= {STAGES{RESET_VAL}};
        else      chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/clkstop_datapath.sv
`timescale 1ns/1ps
module clkstop_datapath
  import clkstop_pkg::*;
#(
  parameter int             ADDR_W     = 24,
  parameter int             FC_W       = 3,
  parameter logic [FC_W-1:0] MATCH_FC  = FC_W'(5),
  parameter int             WORD_FETCH = 2,
  parameter int             BYTE_FETCH = 3
) (
  input  logic              sysClk,
  input  logic              rstInt,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic              rdWr,
  input  logic [FC_W-1:0]   funcCode,
  input  logic              asN,
  input  logic              ackN,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] sleepAddr,
  input  ctlStrobe_t        strb,
  output busStat_t          stat,
  output logic              runEn,
  output logic              cpuClk
);

  localparam int MAX_CYC = (WORD_FETCH > BYTE_FETCH) ? WORD_FETCH : BYTE_FETCH;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_FETCH - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_FETCH - 1);

  logic             asPrev;
  logic             ackSeen;
  logic             matchSeen;
  logic             addrHit;
  logic [CNT_W-1:0] cycCount;
  logic [CNT_W-1:0] lastIdx;

  // supervisor-data write to the chosen address
  assign addrHit = (addrBus == sleepAddr) && !rdWr && (funcCode == MATCH_FC);

  // per-cycle observation, cleared while the strobe is idle
  always_ff @(posedge sysClk or posedge rstInt) begin
    if (rstInt) begin
      asPrev    <= 1'b1;
      ackSeen   <= 1'b0;
      matchSeen <= 1'b0;
    end else begin
      asPrev <= asN;
      if (asN) begin
        ackSeen   <= 1'b0;
        matchSeen <= 1'b0;
      end else begin
        if (!ackN)   ackSeen   <= 1'b1;
        if (addrHit) matchSeen <= 1'b1;
      end
    end
  end

  // acknowledged cycle ends when the strobe negates
  assign stat.cycleEnd   = asN && !asPrev && ackSeen;
  assign stat.cycleMatch = matchSeen;

  // bus-cycle counter
  always_ff @(posedge sysClk or posedge rstInt) begin
    if (rstInt)            cycCount <= '0;
    else if (strb.clrCnt)  cycCount <= '0;
    else if (strb.loadOne) cycCount <= CNT_W'(1);
    else if (strb.incCnt)  cycCount <= cycCount + CNT_W'(1);
  end

  assign lastIdx      = byteMode ? BYTE_LAST : WORD_LAST;
  assign stat.atFinal = (cycCount == lastIdx);

  // enable updated only at the falling edge: whole pulses only
  always_ff @(negedge sysClk) begin
    if (rstInt) runEn <= 1'b1;
    else        runEn <= strb.wantRun;
  end

  assign cpuClk = sysClk & runEn;

endmodule

// File: rtl/clkstop_fsm.sv
`timescale 1ns/1ps
module clkstop_fsm
  import clkstop_pkg::*;
(
  input  logic       sysClk,
  input  logic       rstInt,
  input  busStat_t   stat,
  input  logic       wakeSync,
  output ctlStrobe_t strb,
  output ctlState_t  ctlState
);

  ctlState_t nextState;
  logic      wantRunQ;
  logic      wantRunD;

  always_comb begin
    nextState    = ctlState;
    wantRunD     = wantRunQ;
    strb.loadOne = 1'b0;
    strb.incCnt  = 1'b0;
    strb.clrCnt  = 1'b0;
    strb.wantRun = wantRunQ;
    case (ctlState)
      ST_IDLE: begin
        if (stat.cycleEnd && stat.cycleMatch) begin
          strb.loadOne = 1'b1;
          nextState    = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (stat.cycleEnd) begin
          if (stat.atFinal) begin
            nextState = ST_HALT;
            wantRunD  = 1'b0;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (wakeSync) begin
          nextState   = ST_IDLE;
          wantRunD    = 1'b1;
          strb.clrCnt = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge sysClk or posedge rstInt) begin
    if (rstInt) begin
      ctlState <= ST_IDLE;
      wantRunQ <= 1'b1;
    end else begin
      ctlState <= nextState;
      wantRunQ <= wantRunD;
    end
  end

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int FC_W        = 3,
  parameter int WORD_FETCH  = 2,
  parameter int BYTE_FETCH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sysClk,
  input  logic              resetReq,
  input  logic              wakeReq,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic              rdWr,
  input  logic [FC_W-1:0]   funcCode,
  input  logic              asN,
  input  logic              ackN,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] sleepAddr,
  output logic              cpuClk
);

  logic       rstInt;
  logic       wakeSync;
  logic       runEn;
  ctlStrobe_t strb;
  busStat_t   stat;
  ctlState_t  ctlState;

  // reset: asserts at once, releases on the clock
  clkstop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rstSync (
    .clk (sysClk),
    .arst(resetReq),
    .d   (1'b0),
    .q   (rstInt)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_wakeSync (
    .clk (sysClk),
    .arst(rstInt),
    .d   (wakeReq),
    .q   (wakeSync)
  );

  clkstop_datapath #(
    .ADDR_W    (ADDR_W),
    .FC_W      (FC_W),
    .WORD_FETCH(WORD_FETCH),
    .BYTE_FETCH(BYTE_FETCH)
  ) u_dp (
    .sysClk   (sysClk),
    .rstInt   (rstInt),
    .addrBus  (addrBus),
    .rdWr     (rdWr),
    .funcCode (funcCode),
    .asN      (asN),
    .ackN     (ackN),
    .byteMode (byteMode),
    .sleepAddr(sleepAddr),
    .strb     (strb),
    .stat     (stat),
    .runEn    (runEn),
    .cpuClk   (cpuClk)
  );

  clkstop_fsm u_fsm (
    .sysClk  (sysClk),
    .rstInt  (rstInt),
    .stat    (stat),
    .wakeSync(wakeSync),
    .strb    (strb),
    .ctlState(ctlState)
  );

endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk
  import clkstop_pkg::*;
(
  input logic      sysClk,
  input logic      rstInt,
  input logic      runEn,
  input logic      wantRun,
  input ctlState_t ctlState,
  input logic      cycleEnd,
  input logic      cycleMatch,
  input logic      atFinal,
  input logic      wakeSync
);

  // R1: an unmatched cycle leaves the controller idle
  p_idle_hold_r1: assert property (@(posedge sysClk) disable iff (rstInt)
    (ctlState == ST_IDLE && cycleEnd && !cycleMatch) |=> (ctlState == ST_IDLE));

  // R3: the final counted cycle drops the run request
  p_stop_final_r3: assert property (@(posedge sysClk) disable iff (rstInt)
    (ctlState == ST_COUNT && cycleEnd && atFinal) |=> (ctlState == ST_HALT && !wantRun));

  // R5: a synchronized wake reopens the gate
  p_wake_run_r5: assert property (@(posedge sysClk) disable iff (rstInt)
    (ctlState == ST_HALT && wakeSync) |=> (ctlState == ST_IDLE && wantRun));

  // R8: stopped state holds without a wake
  p_halt_hold_r8: assert property (@(posedge sysClk) disable iff (rstInt)
    (ctlState == ST_HALT && !wakeSync) |=> (ctlState == ST_HALT && !wantRun));

  // R6: the gate reflects the request by the next rising edge
  p_gate_track_r6: assert property (@(posedge sysClk) disable iff (rstInt)
    runEn == wantRun);

  // R6: the gate enable only moves while the system clock is low
  always @(runEn) begin
    if (!rstInt) begin
      p_no_runt_r6: assert (sysClk == 1'b0);
    end
  end

endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
  .sysClk    (sysClk),
  .rstInt    (rstInt),
  .runEn     (runEn),
  .wantRun   (strb.wantRun),
  .ctlState  (ctlState),
  .cycleEnd  (stat.cycleEnd),
  .cycleMatch(stat.cycleMatch),
  .atFinal   (stat.atFinal),
  .wakeSync  (wakeSync)
);

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;

  localparam logic [23:0] SLEEP_A = 24'h3A5C71;
  localparam logic [23:0] OTHER_A = 24'h001230;

  // {byteMode, addrHit, rdWr, fc[2:0], acked, follow[2:0], stopAt[2:0], pad[2:0]}
  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b0, 3'b101, 1'b1, 3'd3, 3'd2, 3'd0},  // R3 word mode stop
    {1'b1, 1'b1, 1'b0, 3'b101, 1'b1, 3'd3, 3'd3, 3'd0},  // R4 byte mode stop
    {1'b0, 1'b1, 1'b1, 3'b101, 1'b1, 3'd3, 3'd0, 3'd0},  // R1 read never arms
    {1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 3'd3, 3'd0, 3'd0},  // R1 user space
    {1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 3'd3, 3'd0, 3'd0},  // R1 other address
    {1'b0, 1'b1, 1'b0, 3'b101, 1'b0, 3'd3, 3'd0, 3'd0},  // R2 no acknowledge
    {1'b1, 1'b1, 1'b0, 3'b101, 1'b1, 3'd1, 3'd0, 3'd0}   // R4 two cycles only
  };
  string vecTag [NVEC] = '{"R3", "R4", "R1", "R1", "R1", "R2", "R4"};

  logic        sysClk   = 1'b0;
  logic        resetReq = 1'b0;
  logic        wakeReq  = 1'b0;
  logic [23:0] addrBus  = '0;
  logic        rdWr     = 1'b1;
  logic [2:0]  funcCode = 3'b110;
  logic        asN      = 1'b1;
  logic        ackN     = 1'b1;
  logic        byteMode = 1'b0;
  logic [23:0] sleepAddr = SLEEP_A;
  logic        cpuClk;

  int nChecks = 0;
  int nFail   = 0;
  int pulses  = 0;
  int badWidth = 0;
  time riseT = 0;

  clkstop_ctrl uut (
    .sysClk   (sysClk),
    .resetReq (resetReq),
    .wakeReq  (wakeReq),
    .addrBus  (addrBus),
    .rdWr     (rdWr),
    .funcCode (funcCode),
    .asN      (asN),
    .ackN     (ackN),
    .byteMode (byteMode),
    .sleepAddr(sleepAddr),
    .cpuClk   (cpuClk)
  );

  always #5 sysClk = ~sysClk;

  always @(posedge cpuClk) begin
    pulses++;
    riseT = $time;
  end
  always @(negedge cpuClk) begin
    if ($time - riseT != 5) badWidth++;
  end

  task automatic check(input string tag, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic busCycle(input logic [23:0] a, input logic rw,
                          input logic [2:0] fc, input logic acked);
    @(negedge sysClk);
    addrBus = a; rdWr = rw; funcCode = fc; asN = 1'b0; ackN = 1'b1;
    @(negedge sysClk);
    ackN = !acked;
    @(negedge sysClk);
    @(negedge sysClk);
    asN = 1'b1; ackN = 1'b1; rdWr = 1'b1;
  endtask

  // run a cycle, then count the pulses on the next four rising edges
  task automatic cycleChk(input string tag, input int idx, input int stopAt,
                          input logic [23:0] a, input logic rw,
                          input logic [2:0] fc, input logic acked);
    int p0;
    int expv;
    busCycle(a, rw, fc, acked);
    p0 = pulses;
    repeat (4) @(posedge sysClk);
    #1;
    if (stopAt != 0 && idx == stopAt)     expv = p0 + 1;
    else if (stopAt != 0 && idx > stopAt) expv = p0;
    else                                  expv = p0 + 4;
    check(tag, pulses, expv);
  endtask

  task automatic doReset();
    @(negedge sysClk);
    resetReq = 1'b1;
    wakeReq  = 1'b0;
    repeat (3) @(posedge sysClk);
    @(negedge sysClk);
    resetReq = 1'b0;
    repeat (4) @(posedge sysClk);
  endtask

  task automatic wakeUp();
    @(negedge sysClk);
    wakeReq = 1'b1;
    repeat (5) @(posedge sysClk);
    @(negedge sysClk);
    wakeReq = 1'b0;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge sysClk);
    nFail++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    int p0;
    #1 resetReq = 1'b1;
    // R7: clock runs while reset is held
    p0 = pulses;
    repeat (4) @(posedge sysClk);
    #1;
    check("R7", (pulses >= p0 + 3) ? 1 : 0, 1);
    @(negedge sysClk);
    resetReq = 1'b0;
    repeat (4) @(posedge sysClk);

    // vector table
    for (int e = 0; e < NVEC; e++) begin
      logic [15:0] v;
      logic [23:0] a;
      v = VEC[e];
      byteMode = v[15];
      doReset();
      a = v[14] ? SLEEP_A : (SLEEP_A ^ 24'h000100);
      cycleChk(vecTag[e], 1, int'(v[5:3]), a, v[13], v[12:10], v[9]);
      for (int f = 0; f < int'(v[8:6]); f++)
        cycleChk(vecTag[e], f + 2, int'(v[5:3]), OTHER_A + 24'(2 * f), 1'b1, 3'b110, 1'b1);
    end

    // R3: exact stop point in word mode
    byteMode = 1'b0;
    doReset();
    busCycle(SLEEP_A, 1'b0, 3'b101, 1'b1);
    busCycle(OTHER_A, 1'b1, 3'b110, 1'b1);
    p0 = pulses;
    repeat (6) @(posedge sysClk);
    #1;
    check("R3", pulses, p0 + 1);
    check("R6", int'(cpuClk), 0);  // mid high phase of sysClk, gated low

    // R5: restart latency
    @(negedge sysClk);
    wakeReq = 1'b1;
    p0 = pulses;
    repeat (3) @(posedge sysClk);
    #1;
    check("R5", pulses, p0);
    @(posedge sysClk);
    #1;
    check("R5", pulses, p0 + 1);
    @(negedge sysClk);
    wakeReq = 1'b0;

    // R8: count restarts after wake; one ordinary cycle does not stop
    cycleChk("R8", 1, 0, OTHER_A, 1'b1, 3'b110, 1'b1);
    cycleChk("R8", 2, 0, OTHER_A, 1'b1, 3'b110, 1'b1);

    // R8: wake request while running has no effect
    wakeUp();
    cycleChk("R8", 1, 2, SLEEP_A, 1'b0, 3'b101, 1'b1);
    cycleChk("R8", 2, 2, OTHER_A, 1'b1, 3'b110, 1'b1);
    wakeUp();

    // R7: reset throws away a partial count
    busCycle(SLEEP_A, 1'b0, 3'b101, 1'b1);
    doReset();
    cycleChk("R7", 1, 0, OTHER_A, 1'b1, 3'b110, 1'b1);
    cycleChk("R7", 2, 0, OTHER_A, 1'b1, 3'b110, 1'b1);

    // R9: top of the address range, near miss first
    @(negedge sysClk);
    resetReq = 1'b1;
    sleepAddr = 24'hFFFFFF;
    repeat (3) @(posedge sysClk);
    @(negedge sysClk);
    resetReq = 1'b0;
    repeat (4) @(posedge sysClk);
    cycleChk("R9", 1, 0, 24'hFFFFFE, 1'b0, 3'b101, 1'b1);
    cycleChk("R9", 2, 0, OTHER_A, 1'b1, 3'b110, 1'b1);
    cycleChk("R9", 1, 2, 24'hFFFFFF, 1'b0, 3'b101, 1'b1);
    cycleChk("R9", 2, 2, OTHER_A, 1'b1, 3'b110, 1'b1);
    wakeUp();

    // R6: every pulse seen was a full half period
    check("R6", badWidth, 0);

    finish();
  end

endmodule